// File: doc/BRIEF.md
# Three-Channel Programmable Down Counter

The block holds three independent 16-bit down counters behind a byte-wide programming port. Software first writes a control byte that picks a counter and sets how that counter's count is written and read (low byte, high byte, or low then high), its counting mode, and whether it counts in binary or in four-digit BCD. It then writes the starting count. Each counter has its own count enable (`ctr_tick`, one pulse per counted clock), its own gate input, and its own output line. Supported modes are interrupt-on-terminal-count and rate generation.

The count can be read at any time, including while it is running. A counter-latch command, or a read-back command that covers any set of counters, freezes a snapshot of the count. The snapshot holds until software has read every byte of it, so a two-byte read cannot mix a low byte and a high byte taken at different counts.

Each counter runs a small state machine. `ST_IDLE` waits for a count after a control write. `ST_HALF` holds the first byte of a two-byte count. `ST_RUN` counts. `ST_TERM` is the state of a terminal-count counter that has reached zero. The transitions are: control write to `ST_IDLE` from any state; final count byte to `ST_RUN`; first of two count bytes to `ST_HALF`; in the terminal-count mode, `ST_RUN` to `ST_TERM` on the tick that brings the count to zero. A new count returns `ST_TERM` to `ST_RUN`, and the first byte of a two-byte count moves it to `ST_HALF`.

Top module: `tri_down_timer`

## Requirements
- R1: After reset all outputs are high, `rdata` is 0 and every counter holds count 0, with read format 00 so that no count write is accepted.
- R2: A write to address 3 is a control byte. Bits [7:6] select counter 0, 1 or 2 (11 is read-back). Bits [5:4] are the access format. Bits [3:1] are the mode: bit 1 set means rate generator, otherwise terminal-count mode. Bit 0 set means BCD. A control byte with format other than 00 resets the counter to `ST_IDLE` and drives its output low in terminal-count mode and high in rate-generator mode.
- R3: A count write to address 0–2 follows the access format. With 01 the byte is the low byte and the high byte becomes 0. With 10 the byte is the high byte and the low byte becomes 0. With 11 the first write is the low byte and the second the high byte, and counting is suspended between them.
- R4: On each cycle with `ctr_tick` and `ctr_gate` both high, a running counter decrements by one; with the gate low the count holds.
- R5: In BCD the count decrements as four decimal digits, and 0000 wraps to 9999. A loaded 0 reaches zero again after 10000 ticks in BCD and after 65536 ticks in binary.
- R6: In terminal-count mode the output is low from the count write until the tick that brings the count to 0, when it goes high. It stays high while the count keeps decrementing and wraps.
- R7: In rate-generator mode with count N ≥ 2, after k ticks the count is N − (k mod N), and the output is low exactly while the count is 1, that is for one tick in every N.
- R8: A read at address 0–2 puts one byte of the counter on `rdata` in the cycle after `rd_en`, ordered by the access format (11: low byte then high byte). `rdata` changes only on a read. Reading address 3 returns 0.
- R9: A control byte with format 00 latches the selected counter's count. Reads return the latched value until every byte of the format has been read, and a further latch command while a snapshot is held is ignored.
- R10: A control byte with bits [7:6] = 11 and bit 5 = 0 latches every counter whose select bit is set (bit 1 for counter 0, bit 2 for counter 1, bit 3 for counter 2). With bit 5 = 1 it latches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 2 | 0–2 counter data, 3 control byte |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, registered |
| ctr_tick | input | 3 | Per-counter count enable |
| ctr_gate | input | 3 | Per-counter gate, low suspends counting |
| ctr_out | output | 3 | Per-counter output line |

## Verification
On every cycle the assertions check the following:
- A terminal-count output stays low while its counter is loading or running, and rises only when the count is zero.
- A rate-generator low pulse lasts a single tick.
- A low gate freezes the count.
- A held snapshot does not move.
- `rdata` moves only on a read.

Only the bench's scenarios can show that the counts are correct:
- exact decrement values in binary and BCD;
- the byte ordering of writes and reads;
- the 65536-tick and 10000-tick spans of a zero load;
- the set of counters a read-back command actually latches.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int DIGITS = CNT_W / 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HALF = 2'd1,
        ST_RUN  = 2'd2,
        ST_TERM = 2'd3
    } cnt_state_e;

    typedef enum logic [1:0] {
        RW_LATCH = 2'b00,
        RW_LO    = 2'b01,
        RW_HI    = 2'b10,
        RW_BOTH  = 2'b11
    } rw_fmt_e;

    typedef struct packed {
        rw_fmt_e    rw;
        logic [2:0] mode;
        logic       bcd;
    } ctr_cfg_t;

    function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] v, input logic bcd);
        logic [CNT_W-1:0] r;
        logic             borrow;
        if (!bcd) begin
            r = v - CNT_W'(1);
        end else begin
            r      = v;
            borrow = 1'b1;
            for (int d = 0; d < DIGITS; d++) begin
                if (borrow) begin
                    if (v[d*4 +: 4] == 4'd0) begin
                        r[d*4 +: 4] = 4'd9;
                    end else begin
                        r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
                        borrow      = 1'b0;
                    end
                end
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/tdt_decode.sv
module tdt_decode
    import tdt_pkg::*;
#(
    parameter int NUM_CTRS = 3,
    localparam int AW      = $clog2(NUM_CTRS + 1)
) (
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [AW-1:0]       addr,
    input  logic [BYTE_W-1:0]   wdata,
    output ctr_cfg_t            cfg_bus,
    output logic [NUM_CTRS-1:0] cfg_wr,
    output logic [NUM_CTRS-1:0] latch_req,
    output logic [NUM_CTRS-1:0] data_wr,
    output logic [NUM_CTRS-1:0] data_rd
);
    logic       wr_ctrl;
    logic [1:0] sel;
    logic       readback;

    assign wr_ctrl  = wr_en && (addr == AW'(NUM_CTRS));
    assign sel      = wdata[7:6];
    assign readback = (sel == 2'b11);
    assign cfg_bus  = ctr_cfg_t'(wdata[5:0]);

    for (genvar i = 0; i < NUM_CTRS; i++) begin : g_strobe
        logic hit;
        assign hit          = wr_ctrl && (sel == 2'(i));
        assign cfg_wr[i]    = hit && (cfg_bus.rw != RW_LATCH);
        assign latch_req[i] = (hit && (cfg_bus.rw == RW_LATCH))
                           || (wr_ctrl && readback && !wdata[5] && wdata[1 + i]);
        assign data_wr[i]   = wr_en && (addr == AW'(i));
        assign data_rd[i]   = rd_en && (addr == AW'(i));
    end
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter
    import tdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              gate,
    input  logic              cfg_wr,
    input  ctr_cfg_t          cfg_in,
    input  logic              latch_req,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              out_o
);
    cnt_state_e        state_q, state_d;
    ctr_cfg_t          cfg_q;
    logic [CNT_W-1:0]  count_q, count_d;
    logic [CNT_W-1:0]  reload_q, reload_d;
    logic [BYTE_W-1:0] lo_hold_q, lo_hold_d;
    logic              wr_hi_q, wr_hi_d;
    logic              out_q, out_d;
    logic              rd_hi_q;
    logic              latched_q;
    logic [CNT_W-1:0]  latch_val_q;
    logic              rate;
    logic              load_fire;
    logic [CNT_W-1:0]  load_val;
    logic [CNT_W-1:0]  dec_val;
    logic [CNT_W-1:0]  rd_src;
    logic              hi_sel;

    assign rate    = cfg_q.mode[1];
    assign dec_val = count_step(count_q, cfg_q.bcd);

    always_comb begin
        state_d   = state_q;
        count_d   = count_q;
        reload_d  = reload_q;
        out_d     = out_q;
        wr_hi_d   = wr_hi_q;
        lo_hold_d = lo_hold_q;
        load_fire = 1'b0;
        load_val  = '0;
        if (cfg_wr) begin
            state_d = ST_IDLE;
            wr_hi_d = 1'b0;
            out_d   = cfg_in.mode[1];
        end else if (data_wr) begin
            case (cfg_q.rw)
                RW_LO: begin
                    load_fire = 1'b1;
                    load_val  = {{BYTE_W{1'b0}}, wdata};
                end
                RW_HI: begin
                    load_fire = 1'b1;
                    load_val  = {wdata, {BYTE_W{1'b0}}};
                end
                RW_BOTH: begin
                    if (!wr_hi_q) begin
                        wr_hi_d   = 1'b1;
                        lo_hold_d = wdata;
                        state_d   = ST_HALF;
                        if (!rate) out_d = 1'b0;
                    end else begin
                        wr_hi_d   = 1'b0;
                        load_fire = 1'b1;
                        load_val  = {wdata, lo_hold_q};
                    end
                end
                default: ;
            endcase
            if (load_fire) begin
                state_d  = ST_RUN;
                count_d  = load_val;
                reload_d = load_val;
                out_d    = rate;
            end
        end else if (tick && gate) begin
            unique case (state_q)
                ST_RUN, ST_TERM: begin
                    if (rate) begin
                        count_d = (count_q == CNT_W'(1)) ? reload_q : dec_val;
                        out_d   = (count_d != CNT_W'(1));
                    end else begin
                        count_d = dec_val;
                        if (state_q == ST_RUN && dec_val == '0) begin
                            state_d = ST_TERM;
                            out_d   = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            count_q   <= '0;
            reload_q  <= '0;
            lo_hold_q <= '0;
            wr_hi_q   <= 1'b0;
            out_q     <= 1'b1;
        end else begin
            if (cfg_wr) cfg_q <= cfg_in;
            count_q   <= count_d;
            reload_q  <= reload_d;
            lo_hold_q <= lo_hold_d;
            wr_hi_q   <= wr_hi_d;
            out_q     <= out_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_hi_q     <= 1'b0;
            latched_q   <= 1'b0;
            latch_val_q <= '0;
        end else if (cfg_wr) begin
            rd_hi_q   <= 1'b0;
            latched_q <= 1'b0;
        end else begin
            if (latch_req && !latched_q) begin
                latched_q   <= 1'b1;
                latch_val_q <= count_q;
            end
            if (data_rd) begin
                if (cfg_q.rw == RW_BOTH) rd_hi_q <= !rd_hi_q;
                if (cfg_q.rw != RW_BOTH || rd_hi_q) latched_q <= 1'b0;
            end
        end
    end

    assign rd_src  = latched_q ? latch_val_q : count_q;
    assign hi_sel  = (cfg_q.rw == RW_HI) || (cfg_q.rw == RW_BOTH && rd_hi_q);
    assign rd_byte = hi_sel ? rd_src[CNT_W-1 -: BYTE_W] : rd_src[BYTE_W-1:0];
    assign out_o   = out_q;

    assert_mode0_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN || state_q == ST_HALF) && !rate) |-> !out_q);

    assert_tc_rise_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_q) && !rate) |-> (count_q == '0));

    assert_rate_one_tick_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate && state_q == ST_RUN && !out_q && tick && gate && !cfg_wr && !data_wr
         && reload_q != CNT_W'(1)) |=> out_q);

    assert_gate_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN || state_q == ST_TERM) && !gate && !data_wr && !cfg_wr)
        |=> $stable(count_q));

    assert_latch_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_q && !data_rd && !cfg_wr) |=> (latched_q && $stable(latch_val_q)));
endmodule

// File: rtl/tri_down_timer.sv
module tri_down_timer
    import tdt_pkg::*;
#(
    parameter int NUM_CTRS = 3,
    localparam int AW      = $clog2(NUM_CTRS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [AW-1:0]       addr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   rdata,
    input  logic [NUM_CTRS-1:0] ctr_tick,
    input  logic [NUM_CTRS-1:0] ctr_gate,
    output logic [NUM_CTRS-1:0] ctr_out
);
    ctr_cfg_t                              cfg_bus;
    logic [NUM_CTRS-1:0]                   cfg_wr, latch_req, data_wr, data_rd;
    logic [NUM_CTRS-1:0][BYTE_W-1:0]       rd_bytes;
    logic [BYTE_W-1:0]                     rd_mux;

    tdt_decode #(.NUM_CTRS(NUM_CTRS)) u_decode (
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .cfg_bus   (cfg_bus),
        .cfg_wr    (cfg_wr),
        .latch_req (latch_req),
        .data_wr   (data_wr),
        .data_rd   (data_rd)
    );

    for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
        tdt_counter u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (ctr_tick[i]),
            .gate      (ctr_gate[i]),
            .cfg_wr    (cfg_wr[i]),
            .cfg_in    (cfg_bus),
            .latch_req (latch_req[i]),
            .data_wr   (data_wr[i]),
            .data_rd   (data_rd[i]),
            .wdata     (wdata),
            .rd_byte   (rd_bytes[i]),
            .out_o     (ctr_out[i])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CTRS; i++) begin
            if (addr == AW'(i)) rd_mux = rd_bytes[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/test_tri_down_timer.sv
module test_tri_down_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] tick = '0, gate = 3'b111;
    logic [2:0] outs;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_down_timer i_tri_down_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ctr_tick(tick), .ctr_gate(gate), .ctr_out(outs)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic cfg(input int ch, input logic [1:0] rw, input logic [2:0] mode, input logic bcd);
        bus_wr(2'd3, {2'(ch), rw, mode, bcd});
    endtask

    task automatic load16(input int ch, input logic [15:0] v);
        bus_wr(2'(ch), v[7:0]);
        bus_wr(2'(ch), v[15:8]);
    endtask

    task automatic read16(input int ch, output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_rd(2'(ch), lo);
        bus_rd(2'(ch), hi);
        v = {hi, lo};
    endtask

    task automatic run(input logic [2:0] mask, input int n);
        if (n > 0) begin
            @(negedge clk); tick = mask;
            repeat (n) @(negedge clk);
            tick = '0;
        end
    endtask

    function automatic logic [15:0] to_bcd(input int v);
        logic [15:0] r;
        int          t;
        t = v;
        for (int d = 0; d < 4; d++) begin
            r[d*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        int          vals[5] = '{1, 2, 7, 300, 16'h1234};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", outs, 3'b111);
        chk("R1 rdata after reset", rdata, 0);
        bus_rd(2'd0, b);
        chk("R1 count after reset", b, 0);
        bus_wr(2'd1, 8'h55);
        bus_rd(2'd1, b);
        chk("R1 count write ignored before setup", b, 0);

        // R2 R3 R6 R8 sweep over counters and counts, binary terminal-count mode
        for (int ch = 0; ch < 3; ch++) begin
            foreach (vals[j]) begin
                cfg(ch, 2'b11, 3'b000, 1'b0);
                chk("R2 control write drives output low", outs[ch], 0);
                load16(ch, 16'(vals[j]));
                chk("R6 output low after load", outs[ch], 0);
                run(3'b001 << ch, vals[j] - 1);
                read16(ch, v);
                chk("R8 count one before terminal", v, 1);
                chk("R6 output low before terminal", outs[ch], 0);
                run(3'b001 << ch, 1);
                chk("R6 output high at terminal", outs[ch], 1);
                read16(ch, v);
                chk("R6 count zero at terminal", v, 0);
                run(3'b001 << ch, 1);
                read16(ch, v);
                chk("R6 count wraps after terminal", v, 16'hFFFF);
                chk("R6 output stays high", outs[ch], 1);
            end
        end

        // R4 gate
        cfg(1, 2'b11, 3'b000, 1'b0);
        load16(1, 16'd100);
        gate[1] = 1'b0;
        run(3'b010, 20);
        read16(1, v);
        chk("R4 gate low holds count", v, 100);
        gate[1] = 1'b1;
        run(3'b010, 20);
        read16(1, v);
        chk("R4 gate high counts", v, 80);

        // R5 BCD
        cfg(2, 2'b11, 3'b000, 1'b1);
        load16(2, 16'h1234);
        for (int k = 1; k <= 40; k++) begin
            run(3'b100, 1);
            read16(2, v);
            chk("R5 BCD decrement", v, to_bcd(1234 - k));
        end
        load16(2, 16'h0000);
        run(3'b100, 1);
        read16(2, v);
        chk("R5 BCD wrap to 9999", v, 16'h9999);
        load16(2, 16'h0000);
        run(3'b100, 9999);
        chk("R5 BCD zero load not yet terminal", outs[2], 0);
        run(3'b100, 1);
        chk("R5 BCD zero load terminal at 10000", outs[2], 1);
        cfg(0, 2'b11, 3'b000, 1'b0);
        load16(0, 16'h0000);
        run(3'b001, 65535);
        chk("R5 binary zero load not yet terminal", outs[0], 0);
        run(3'b001, 1);
        chk("R5 binary zero load terminal at 65536", outs[0], 1);

        // R3 byte formats
        cfg(0, 2'b01, 3'b000, 1'b0);
        bus_wr(2'd0, 8'h37);
        bus_rd(2'd0, b);
        chk("R3 low-byte-only load", b, 8'h37);
        chk("R3 output low after low-byte load", outs[0], 0);
        cfg(0, 2'b10, 3'b000, 1'b0);
        bus_wr(2'd0, 8'h02);
        bus_rd(2'd0, b);
        chk("R3 high-byte-only load", b, 8'h02);
        run(3'b001, 1);
        bus_rd(2'd0, b);
        chk("R3 high-only load clears low byte", b, 8'h01);
        cfg(0, 2'b11, 3'b000, 1'b0);
        load16(0, 16'd50);
        bus_wr(2'd0, 8'h10);
        run(3'b001, 5);
        bus_wr(2'd0, 8'h00);
        read16(0, v);
        chk("R3 two-byte load suspends then loads", v, 16'h0010);

        // R7 rate generator
        for (int n = 2; n <= 5; n++) begin
            cfg(1, 2'b11, 3'b010, 1'b0);
            chk("R7 rate mode control drives output high", outs[1], 1);
            load16(1, 16'(n));
            @(negedge clk); tick = 3'b010;
            for (int k = 1; k <= 3 * n; k++) begin
                @(negedge clk);
                chk("R7 rate output", outs[1], (k % n == n - 1) ? 0 : 1);
            end
            tick = '0;
            read16(1, v);
            chk("R7 rate count after whole periods", v, n);
        end

        // R9 counter latch
        cfg(0, 2'b11, 3'b000, 1'b0);
        load16(0, 16'd500);
        run(3'b001, 10);
        bus_wr(2'd3, 8'h00);
        run(3'b001, 7);
        bus_wr(2'd3, 8'h00);
        run(3'b001, 3);
        read16(0, v);
        chk("R9 latched value held", v, 490);
        read16(0, v);
        chk("R9 live value after release", v, 480);

        // R10 read-back
        cfg(0, 2'b11, 3'b000, 1'b0); load16(0, 16'd1000);
        cfg(1, 2'b11, 3'b000, 1'b0); load16(1, 16'd2000);
        cfg(2, 2'b11, 3'b000, 1'b0); load16(2, 16'd3000);
        bus_wr(2'd3, 8'hD6);
        run(3'b111, 5);
        read16(0, v);
        chk("R10 read-back latched counter 0", v, 1000);
        read16(1, v);
        chk("R10 read-back latched counter 1", v, 2000);
        read16(2, v);
        chk("R10 read-back left counter 2 live", v, 2995);
        bus_wr(2'd3, 8'hEE);
        run(3'b111, 5);
        read16(0, v);
        chk("R10 read-back with bit 5 set latches nothing", v, 990);
        bus_rd(2'd3, b);
        chk("R8 control address reads zero", b, 0);

        done = 1'b1;
        report();
    end
endmodule